// File: doc/BRIEF.md
# Nearest-Rate Integer Clock Divider

The block turns a parent clock into a slower tick stream whose rate comes from an 8-bit integer divide factor. Software can set the factor directly. It can also send a target rate together with the present parent rate. The block then works out the factor whose output rate lands closest to the target, limits it to 1..255 and stores it. If the limit had to be applied, a sticky error flag records it. A read-back command divides the parent rate by the stored factor and reports the rate the output actually runs at.

One restoring divider, one quotient bit per cycle, does all the arithmetic. A controller steps it through up to three divisions. The states are:

- **IDLE**: accepts commands.
- **CAND**: computes the parent/target candidate.
- **NEAR_A**: computes the parent/candidate rate.
- **NEAR_B**: computes the parent/(candidate+1) rate and then commits the factor.
- **RDBK**: computes the read-back rate.

The transitions are:

- IDLE to CAND on a rate request.
- IDLE to RDBK on a read-back while the factor is non-zero.
- CAND to IDLE when the candidate is 0 or above 255.
- CAND to NEAR_A otherwise.
- NEAR_A to NEAR_B.
- NEAR_B to IDLE.
- RDBK to IDLE.

Each of CAND, NEAR_A, NEAR_B and RDBK moves on when the divider reports done. A tick generator emits one pulse per factor cycles. It picks up a new factor only when the current period ends.

Top module: `near_rate_clkdiv`

## Requirements
- R1: After reset the factor is 0, both error flags are 0, busy, done and div_tick are 0.
- R2: A rate request computes candidate q = parent/target (truncated). For 1 <= q <= 255 the block takes q+1 when |target - parent/(q+1)| <= |target - parent/q| (ties go to the larger factor), else q. The quotients are truncated.
- R3: A resulting factor above 255, including a target of 0, is stored as 255 and sets err_over.
- R4: A candidate of 0 (parent below target) stores factor 1 and sets err_under.
- R5: Error flags stay set until cleared by writing 1 to flag_clr. flag_clr[1] clears err_over and flag_clr[0] clears err_under. A set in the same cycle wins over a clear.
- R6: busy is high from the cycle after a request is accepted until the result is committed. While busy, rate requests, direct writes, off commands and read-backs are ignored.
- R7: In IDLE, fac_wr stores fac_wdata as the factor and off_cmd stores 0. off_cmd has priority over fac_wr, which has priority over req_valid, which has priority over rd_req.
- R8: With a factor N >= 1, div_tick is high for one cycle every N clock cycles. For N = 1 it is high every cycle.
- R9: With a factor of 0, div_tick stays low.
- R10: A factor change takes effect only after the period in progress ends.
- R11: A read-back returns parent/factor on rd_rate with a done pulse. When the factor is 0 it returns 0 on the next cycle.
- R12: done is a one-cycle pulse that comes with the committed result (factor or rd_rate) and never while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| parent_rate | input | RATE_W | Parent clock rate, latched on a request |
| req_valid | input | 1 | Start a nearest-factor computation |
| req_rate | input | RATE_W | Requested output rate |
| fac_wr | input | 1 | Direct factor write strobe |
| fac_wdata | input | FAC_W | Factor value for a direct write |
| off_cmd | input | 1 | Store factor 0 (output off) |
| rd_req | input | 1 | Start a read-back of the output rate |
| flag_clr | input | 2 | Write-one-to-clear: bit 1 err_over, bit 0 err_under |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| factor | output | FAC_W | Stored divide factor |
| rd_rate | output | RATE_W | Result of the last read-back |
| err_over | output | 1 | Sticky: factor was clamped to 255 |
| err_under | output | 1 | Sticky: factor was forced to 1 |
| div_tick | output | 1 | Divided output, one pulse per period |

## Verification
The assertions assume that commands arrive as single-cycle strobes. They also assume that parent_rate stays below 2^RATE_W and that the divider quotient checks see a non-zero divisor, except for the deliberate zero-target case. The stimulus always waits for busy to fall before issuing a command, except in the single directed test that drives commands while busy. Random parent rates stay below 10^8 and random targets are never zero, so the quotient bounds hold. The zero-target and parent-below-target corners are driven only as directed cases.

// File: rtl/ndiv_pkg.sv
package ndiv_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAND,
        ST_NEAR_A,
        ST_NEAR_B,
        ST_RDBK
    } ndiv_state_e;
endpackage

// File: rtl/ndiv_restoring_div.sv
module ndiv_restoring_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     rem_r, quo_r, dvs_r, dvd_r;
    logic [CNT_W-1:0] cnt_r;
    logic [W:0]       rem_sh, rem_sub;
    logic             fits;

    always_comb begin
        rem_sh  = {rem_r, quo_r[W-1]};
        fits    = rem_sh >= {1'b0, dvs_r};
        rem_sub = rem_sh - {1'b0, dvs_r};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_r <= '0;
            quo_r <= '0;
            dvs_r <= '0;
            dvd_r <= '0;
            cnt_r <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else if (start) begin
            rem_r <= '0;
            quo_r <= dividend;
            dvs_r <= divisor;
            dvd_r <= dividend;
            cnt_r <= CNT_W'(W);
            busy  <= 1'b1;
            done  <= 1'b0;
        end else if (busy) begin
            rem_r <= fits ? rem_sub[W-1:0] : rem_sh[W-1:0];
            quo_r <= {quo_r[W-2:0], fits};
            cnt_r <= cnt_r - 1'b1;
            if (cnt_r == CNT_W'(1)) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end else begin
            done <= 1'b0;
        end
    end

    assign quotient = quo_r;

    logic [2*W-1:0] prod_w, dvd_w, dvs_w;
    always_comb begin
        prod_w = {{W{1'b0}}, quo_r} * {{W{1'b0}}, dvs_r};
        dvd_w  = {{W{1'b0}}, dvd_r};
        dvs_w  = {{W{1'b0}}, dvs_r};
    end

    // R2: the quotient handed back is the truncated quotient
    p_quot_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dvs_r != '0) |-> (prod_w <= dvd_w) && ((dvd_w - prod_w) < dvs_w));
    // R3: a zero divisor saturates so the factor clamps high
    p_zero_dvs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dvs_r == '0) |-> (&quo_r));
endmodule

// File: rtl/ndiv_tick_gen.sv
module ndiv_tick_gen #(
    parameter int FAC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FAC_W-1:0] fac_in,
    output logic             tick
);
    logic [FAC_W-1:0] cur_fac, cnt_r;

    assign tick = (cur_fac != '0) && (cnt_r == cur_fac - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_fac <= '0;
            cnt_r   <= '0;
        end else if (cur_fac == '0 || tick) begin
            cur_fac <= fac_in;
            cnt_r   <= '0;
        end else begin
            cnt_r <= cnt_r + 1'b1;
        end
    end

    // R10: the active factor changes only at a period boundary
    p_reload_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_fac != '0 && !tick) |=> $stable(cur_fac));
    // R9: a zero factor seen at a period end silences the next cycle
    p_gate_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && fac_in == '0) |=> !tick);
endmodule

// File: rtl/near_rate_clkdiv.sv
module near_rate_clkdiv #(
    parameter int RATE_W = 32,
    parameter int FAC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] parent_rate,
    input  logic              req_valid,
    input  logic [RATE_W-1:0] req_rate,
    input  logic              fac_wr,
    input  logic [FAC_W-1:0]  fac_wdata,
    input  logic              off_cmd,
    input  logic              rd_req,
    input  logic [1:0]        flag_clr,
    output logic              busy,
    output logic              done,
    output logic [FAC_W-1:0]  factor,
    output logic [RATE_W-1:0] rd_rate,
    output logic              err_over,
    output logic              err_under,
    output logic              div_tick
);
    import ndiv_pkg::*;

    localparam int FAC_MAX = (1 << FAC_W) - 1;
    localparam logic [RATE_W-1:0] FAC_MAX_R = RATE_W'(FAC_MAX);

    ndiv_state_e state, state_nx;

    logic [RATE_W-1:0] tgt_r, par_r, near_a_r;
    logic [FAC_W:0]    cand_r, pick;
    logic [RATE_W-1:0] dist_a, dist_b;

    logic              div_start, div_busy, div_done;
    logic [RATE_W-1:0] div_dvd, div_dvs, div_quo;

    ndiv_restoring_div #(.W(RATE_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (div_dvd),
        .divisor  (div_dvs),
        .busy     (div_busy),
        .done     (div_done),
        .quotient (div_quo)
    );

    ndiv_tick_gen #(.FAC_W(FAC_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .fac_in (factor),
        .tick   (div_tick)
    );

    assign busy = (state != ST_IDLE);

    // nearest-rate pick from the two candidate rates
    always_comb begin
        dist_a = (tgt_r >= near_a_r) ? tgt_r - near_a_r : near_a_r - tgt_r;
        dist_b = (tgt_r >= div_quo)  ? tgt_r - div_quo  : div_quo - tgt_r;
        pick   = (dist_b <= dist_a) ? cand_r + 1'b1 : cand_r;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state and divider launch
    always_comb begin
        state_nx  = state;
        div_start = 1'b0;
        div_dvd   = par_r;
        div_dvs   = '0;
        unique case (state)
            ST_IDLE: begin
                if (off_cmd || fac_wr) begin
                    state_nx = ST_IDLE;
                end else if (req_valid) begin
                    div_start = 1'b1;
                    div_dvd   = parent_rate;
                    div_dvs   = req_rate;
                    state_nx  = ST_CAND;
                end else if (rd_req && factor != '0) begin
                    div_start = 1'b1;
                    div_dvd   = parent_rate;
                    div_dvs   = RATE_W'(factor);
                    state_nx  = ST_RDBK;
                end
            end
            ST_CAND: begin
                if (div_done) begin
                    if (div_quo == '0 || div_quo > FAC_MAX_R) begin
                        state_nx = ST_IDLE;
                    end else begin
                        div_start = 1'b1;
                        div_dvs   = div_quo;
                        state_nx  = ST_NEAR_A;
                    end
                end
            end
            ST_NEAR_A: begin
                if (div_done) begin
                    div_start = 1'b1;
                    div_dvs   = RATE_W'(cand_r) + RATE_W'(1);
                    state_nx  = ST_NEAR_B;
                end
            end
            ST_NEAR_B: if (div_done) state_nx = ST_IDLE;
            ST_RDBK:   if (div_done) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            factor    <= '0;
            rd_rate   <= '0;
            err_over  <= 1'b0;
            err_under <= 1'b0;
            done      <= 1'b0;
            tgt_r     <= '0;
            par_r     <= '0;
            cand_r    <= '0;
            near_a_r  <= '0;
        end else begin
            done      <= 1'b0;
            err_over  <= err_over  & ~flag_clr[1];
            err_under <= err_under & ~flag_clr[0];
            unique case (state)
                ST_IDLE: begin
                    if (off_cmd) begin
                        factor <= '0;
                    end else if (fac_wr) begin
                        factor <= fac_wdata;
                    end else if (req_valid) begin
                        tgt_r <= req_rate;
                        par_r <= parent_rate;
                    end else if (rd_req && factor == '0) begin
                        rd_rate <= '0;
                        done    <= 1'b1;
                    end
                end
                ST_CAND: begin
                    if (div_done) begin
                        if (div_quo == '0) begin
                            factor    <= FAC_W'(1);
                            err_under <= 1'b1;
                            done      <= 1'b1;
                        end else if (div_quo > FAC_MAX_R) begin
                            factor   <= FAC_W'(FAC_MAX);
                            err_over <= 1'b1;
                            done     <= 1'b1;
                        end else begin
                            cand_r <= div_quo[FAC_W:0];
                        end
                    end
                end
                ST_NEAR_A: if (div_done) near_a_r <= div_quo;
                ST_NEAR_B: begin
                    if (div_done) begin
                        if (pick > (FAC_W+1)'(FAC_MAX)) begin
                            factor   <= FAC_W'(FAC_MAX);
                            err_over <= 1'b1;
                        end else begin
                            factor <= pick[FAC_W-1:0];
                        end
                        done <= 1'b1;
                    end
                end
                ST_RDBK: begin
                    if (div_done) begin
                        rd_rate <= div_quo;
                        done    <= 1'b1;
                    end
                end
                default: done <= 1'b0;
            endcase
        end
    end

    // R6: no factor change while busy except the commit that raises done
    p_hold_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(factor) || done));
    // R3: a fresh over-range flag comes with the maximum factor
    p_clamp_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_over) |-> (factor == FAC_W'(FAC_MAX)));
    // R4: a fresh under-range flag comes with factor 1
    p_clamp_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_under) |-> (factor == FAC_W'(1)));
    // R12: completion is reported only once back in IDLE
    p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: tb/tb_near_rate_clkdiv.sv
module tb_near_rate_clkdiv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] parent_rate = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_rate = '0;
    logic        fac_wr = 1'b0;
    logic [7:0]  fac_wdata = '0;
    logic        off_cmd = 1'b0;
    logic        rd_req = 1'b0;
    logic [1:0]  flag_clr = '0;
    logic        busy, done, err_over, err_under, div_tick;
    logic [7:0]  factor;
    logic [31:0] rd_rate;

    int n_checks = 0;
    int n_errs   = 0;

    always #4 clk = ~clk;

    near_rate_clkdiv dut (
        .clk(clk), .rst_n(rst_n), .parent_rate(parent_rate), .req_valid(req_valid),
        .req_rate(req_rate), .fac_wr(fac_wr), .fac_wdata(fac_wdata), .off_cmd(off_cmd),
        .rd_req(rd_req), .flag_clr(flag_clr), .busy(busy), .done(done), .factor(factor),
        .rd_rate(rd_rate), .err_over(err_over), .err_under(err_under), .div_tick(div_tick)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void ref_fac(input longint p, input longint t,
                                    output int f, output bit hi, output bit lo);
        longint q, a, b, da, db, pk;
        hi = 0; lo = 0;
        if (t == 0) begin f = 255; hi = 1; return; end
        q = p / t;
        if (q == 0) begin f = 1; lo = 1; return; end
        if (q > 255) begin f = 255; hi = 1; return; end
        a  = p / q;
        b  = p / (q + 1);
        da = (t >= a) ? t - a : a - t;
        db = (t >= b) ? t - b : b - t;
        pk = (db <= da) ? q + 1 : q;
        if (pk > 255) begin f = 255; hi = 1; end
        else f = int'(pk);
    endfunction

    task automatic wait_done(input string req);
        int k = 0;
        while (!done && k < 3000) begin @(negedge clk); k++; end
        chk(done, req, done, 1);
    endtask

    task automatic clear_flags(input logic [1:0] m);
        @(negedge clk); flag_clr = m;
        @(negedge clk); flag_clr = '0;
    endtask

    task automatic request(input longint p, input longint t);
        @(negedge clk);
        parent_rate = 32'(p); req_rate = 32'(t); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done("R12");
    endtask

    task automatic write_fac(input int v);
        @(negedge clk); fac_wr = 1'b1; fac_wdata = 8'(v);
        @(negedge clk); fac_wr = 1'b0;
    endtask

    task automatic check_req(input longint p, input longint t);
        int f; bit hi, lo;
        ref_fac(p, t, f, hi, lo);
        clear_flags(2'b11);
        request(p, t);
        chk(factor == 8'(f), "R2 factor", factor, f);
        chk(err_over == hi, "R3 err_over", err_over, hi);
        chk(err_under == lo, "R4 err_under", err_under, lo);
    endtask

    task automatic sync_tick();
        int k = 0;
        while (!div_tick && k < 600) begin @(negedge clk); k++; end
    endtask

    task automatic measure(input int exp, input string req);
        int n = 0;
        sync_tick();
        do begin @(negedge clk); n++; end while (!div_tick && n < 600);
        chk(n == exp, req, n, exp);
    endtask

    task automatic readback(input longint exp, input string req);
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        wait_done(req);
        chk(rd_rate == 32'(exp), req, rd_rate, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errs++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(factor == 0 && !err_over && !err_under, "R1 regs", factor, 0);
        chk(!busy && !done && !div_tick, "R1 status", {busy, done, div_tick}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!div_tick && factor == 0, "R1 idle", div_tick, 0);

        // R2 directed: tie goes to larger, exact hit, plain rounding
        check_req(120, 50);
        chk(factor == 3, "R2 tie", factor, 3);
        check_req(120, 60);
        chk(factor == 2, "R2 exact", factor, 2);
        check_req(100, 40);
        check_req(25599, 100);
        // R3 clamp high and zero target
        check_req(1000000, 1000);
        check_req(5000, 0);
        chk(factor == 255 && err_over, "R3 zero target", factor, 255);
        // R4 forced to 1
        check_req(50, 100);
        chk(factor == 1 && err_under, "R4 under", factor, 1);

        // R5 sticky flags with selective clear
        request(50, 100);
        request(1000000, 10);
        chk(err_over && err_under, "R5 both sticky", {err_over, err_under}, 3);
        clear_flags(2'b01);
        chk(err_over && !err_under, "R5 clear under only", {err_over, err_under}, 2);
        clear_flags(2'b10);
        chk(!err_over && !err_under, "R5 clear over", {err_over, err_under}, 0);

        // R6 commands while busy are ignored
        @(negedge clk);
        parent_rate = 120; req_rate = 50; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_rate = 1; fac_wr = 1'b1; fac_wdata = 77;
        off_cmd = 1'b1; rd_req = 1'b1;
        chk(busy, "R6 busy", busy, 1);
        @(negedge clk);
        req_valid = 1'b0; fac_wr = 1'b0; off_cmd = 1'b0; rd_req = 1'b0;
        wait_done("R6 done");
        @(negedge clk);
        chk(factor == 3, "R6 ignored", factor, 3);
        chk(!done, "R12 pulse", done, 0);

        // R7 direct write and off priority
        write_fac(9);
        chk(factor == 9, "R7 write", factor, 9);
        @(negedge clk); fac_wr = 1'b1; fac_wdata = 44; off_cmd = 1'b1;
        @(negedge clk); fac_wr = 1'b0; off_cmd = 1'b0;
        chk(factor == 0, "R7 off priority", factor, 0);

        // R11 read-back of zero factor and of a live factor
        readback(0, "R11 zero");
        write_fac(7);
        parent_rate = 1000;
        readback(142, "R11 rate");

        // R8 periods
        write_fac(1);
        measure(1, "R8 period 1");
        write_fac(4);
        measure(4, "R8 period 4");
        write_fac(255);
        measure(255, "R8 period 255");

        // R10 change lands at period end
        write_fac(5);
        measure(5, "R10 pre");
        begin
            int n = 0;
            sync_tick();
            @(negedge clk); n++; fac_wr = 1'b1; fac_wdata = 3;
            @(negedge clk); n++; fac_wr = 1'b0;
            while (!div_tick && n < 600) begin @(negedge clk); n++; end
            chk(n == 5, "R10 old period kept", n, 5);
            n = 0;
            do begin @(negedge clk); n++; end while (!div_tick && n < 600);
            chk(n == 3, "R10 new period", n, 3);
        end

        // R9 off silences the output
        @(negedge clk); off_cmd = 1'b1;
        @(negedge clk); off_cmd = 1'b0;
        repeat (10) @(negedge clk);
        begin
            int cnt = 0;
            for (int i = 0; i < 300; i++) begin @(negedge clk); if (div_tick) cnt++; end
            chk(cnt == 0, "R9 no ticks", cnt, 0);
        end

        // random requests
        for (int i = 0; i < 30; i++) begin
            longint p, t;
            int d;
            p = longint'($urandom_range(1000, 100000000));
            d = int'($urandom_range(1, 300));
            t = p / d + longint'($urandom_range(0, 32'(p / d / 2)));
            if (t == 0) t = 1;
            check_req(p, t);
            if (i % 6 == 0) begin
                parent_rate = 32'(p);
                readback(p / longint'(factor), "R11 random");
                measure(int'(factor), "R8 random");
            end
        end

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule